// File: doc/BRIEF.md
# Host-Strobed Parallel Byte Bridge

This block joins an on-chip byte stream in each direction to an external host that talks over an 8-bit data bus with four handshake wires. Bytes arriving from the chip side are queued in a receive FIFO. An active-low "byte waiting" flag tells the host it may read. The host pulls its active-low read strobe down, and the falling edge pops the oldest byte onto the bus. In the other direction, an active-low "room available" flag invites the host to write. The host pulses its active-high write strobe, and the falling edge commits the bus value into a transmit FIFO. The chip drains that FIFO through a valid/ready port.

The host strobes and the bus are asynchronous to the block clock. Each one passes through a multi-stage synchroniser before any edge is detected. After every completed host cycle, the matching flag is forced high for a fixed number of clocks, whatever the FIFO fill level. The host therefore always sees a clear gap between cycles. All timing is a synchronous approximation counted in block clocks.

Top module: `par_fifo_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it is released: the byte-waiting flag is high, the room flag is low, the bus output enable is low, `rx_in_ready` is high, `tx_out_valid` is low and `host_data_out` is 0.
- R2: The byte-waiting flag (`host_rxf_n`) is high whenever the receive FIFO is empty. It goes low once a byte has been accepted and no read cycle or hold-off is in progress.
- R3: Each synchronised falling edge of `host_rd_n` removes the oldest receive byte and presents it on `host_data_out`. Bytes leave in the order the chip side supplied them.
- R4: `host_data_oe` is high only during a read strobe, and it rises no earlier than the cycle in which the popped byte is on `host_data_out`. Once `host_rd_n` has been high for three clocks, `host_data_oe` is low.
- R5: Each synchronised falling edge of `host_wr` writes the synchronised bus value into the transmit FIFO. `tx_out_data` delivers those bytes in the order they were written.
- R6: The room flag (`host_txe_n`) is high whenever the transmit FIFO holds `FIFO_DEPTH` bytes. A write strobe while it is full is dropped and never appears on `tx_out_data`.
- R7: A read strobe while the receive FIFO is empty pops nothing. `host_data_out` keeps the last byte read (0 after reset), and later reads still return the stream in order.
- R8: Once the synchronised read strobe returns high, `host_rxf_n` stays high for that cycle and then for `HOLD_CYCLES` further clocks.
- R9: On the synchronised falling edge of `host_wr`, `host_txe_n` stays high for that cycle and then for `HOLD_CYCLES` further clocks.
- R10: `rx_in_ready` is low exactly when the receive FIFO is full. `tx_out_valid` is high whenever the transmit FIFO is not empty. While `tx_out_valid` is high and `tx_out_ready` is low, `tx_out_data` stays stable.
- R11: `host_rxf_n` is high while the synchronised read strobe is low. `host_txe_n` is high while the synchronised write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr | input | 1 | Host write strobe, active high, falling edge commits |
| host_data_in | input | DATA_W | Bus value driven by the host |
| host_data_out | output | DATA_W | Byte presented to the host during a read |
| host_data_oe | output | 1 | Bus drive enable for `host_data_out` |
| host_rxf_n | output | 1 | Low when a byte may be read |
| host_txe_n | output | 1 | Low when a byte may be written |
| rx_in_data | input | DATA_W | Chip-side byte toward the host |
| rx_in_valid | input | 1 | `rx_in_data` is offered |
| rx_in_ready | output | 1 | Receive FIFO can take a byte |
| tx_out_data | output | DATA_W | Oldest byte written by the host |
| tx_out_valid | output | 1 | `tx_out_data` holds a byte |
| tx_out_ready | input | 1 | Chip side takes `tx_out_data` |

## Verification
The bench builds the block with its defaults: 8-bit data, 16-entry FIFOs, two synchroniser stages and a 4-clock hold-off. The shallow FIFOs mean 16 host writes against a stalled sink fill the transmit side, and 16 chip-side pushes fill the receive side. Both the full-flag and the dropped-write corners are therefore reached directly. The short hold-off lets the bench check every clock of each post-cycle flag window exactly. Random interleaving of reads, writes, source pushes and sink back-pressure then exercises ordering across many wrap-arounds of both pointers.

// File: rtl/pfb_pkg.sv
// Shared defaults and helpers for the parallel byte bridge.
package pfb_pkg;
    localparam int unsigned PFB_BYTE_W      = 8;
    localparam int unsigned PFB_FIFO_DEPTH  = 16;
    localparam int unsigned PFB_SYNC_STAGES = 2;
    localparam int unsigned PFB_HOLD_CYCLES = 4;

    // Bits needed to index n items (at least one bit).
    function automatic int unsigned pfb_ptr_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/pfb_sync.sv
// Multi-stage synchroniser for an asynchronous vector.
// Assumes a multi-bit vector is held stable by its source long enough
// that all bits settle in the same sample (true for the host bus here).
module pfb_sync #(
    parameter int unsigned      WIDTH     = 1,
    parameter int unsigned      STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (g == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= RESET_VAL;
                else        r <= d;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= RESET_VAL;
                else        r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/pfb_strobe.sv
// Synchronises one host strobe and keeps its previous synchronised value,
// so the parent can detect either edge. Reset loads the idle level.
module pfb_strobe #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic now,
    output logic prev
);
    pfb_sync #(.WIDTH(1), .STAGES(STAGES), .RESET_VAL(IDLE_LVL)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin),
        .q    (now)
    );

    // One-cycle history of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= now;
    end
endmodule

// File: rtl/pfb_fifo.sv
// Single-clock FIFO with a combinational head. A push when full and a pop
// when empty are ignored. Any depth of 2 or more is accepted.
module pfb_fifo
    import pfb_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = pfb_ptr_w(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign dout    = mem[rptr];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer advance with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    // Fill level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (do_push && !do_pop) count <= count + 1'b1;
        else if (do_pop && !do_push) count <= count - 1'b1;
    end
endmodule

// File: rtl/pfb_holdoff.sv
// Post-cycle hold-off timer. busy is high in the start cycle and for
// HOLD further clocks. A new start reloads the count.
module pfb_holdoff
    import pfb_pkg::*;
#(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = pfb_ptr_w(HOLD + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(HOLD);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = start || (cnt != '0);
endmodule

// File: rtl/par_fifo_bridge.sv
// Host-strobed parallel byte bridge.
// The host reads the receive FIFO with an active-low strobe (the falling
// edge pops) and writes the transmit FIFO with an active-high strobe (the
// falling edge commits). Both strobes and the bus are synchronised into
// clk. Assumes the host holds each strobe level for more than SYNC_STAGES+1
// clocks and keeps the bus stable until SYNC_STAGES clocks after WR falls.
module par_fifo_bridge
    import pfb_pkg::*;
#(
    parameter int unsigned DATA_W      = PFB_BYTE_W,
    parameter int unsigned FIFO_DEPTH  = PFB_FIFO_DEPTH,
    parameter int unsigned SYNC_STAGES = PFB_SYNC_STAGES,
    parameter int unsigned HOLD_CYCLES = PFB_HOLD_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data_in,
    output logic [DATA_W-1:0] host_data_out,
    output logic              host_data_oe,
    output logic              host_rxf_n,
    output logic              host_txe_n,
    input  logic [DATA_W-1:0] rx_in_data,
    input  logic              rx_in_valid,
    output logic              rx_in_ready,
    output logic [DATA_W-1:0] tx_out_data,
    output logic              tx_out_valid,
    input  logic              tx_out_ready
);
    logic              rd_now, rd_prev, wr_now, wr_prev;
    logic [DATA_W-1:0] bus_sync;
    logic              rd_pop_evt, rd_done, wr_commit;
    logic              rx_full, rx_empty, tx_full, tx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              rx_hold, tx_hold;
    logic [DATA_W-1:0] out_byte;
    logic              oe_q;

    // Strobe synchronisers, each reset to its idle level.
    pfb_strobe #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_rd (
        .clk(clk), .rst_n(rst_n), .pin(host_rd_n), .now(rd_now), .prev(rd_prev)
    );
    pfb_strobe #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b0)) u_wr (
        .clk(clk), .rst_n(rst_n), .pin(host_wr), .now(wr_now), .prev(wr_prev)
    );

    // Bus synchroniser with the same latency as the strobes.
    pfb_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_bus (
        .clk(clk), .rst_n(rst_n), .d(host_data_in), .q(bus_sync)
    );

    assign rd_pop_evt = rd_prev && !rd_now;
    assign rd_done    = !rd_prev && rd_now;
    assign wr_commit  = wr_prev && !wr_now;

    // Receive path: chip side pushes, host falling read edge pops.
    pfb_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_in_valid),
        .din  (rx_in_data),
        .pop  (rd_pop_evt),
        .dout (rx_head),
        .full (rx_full),
        .empty(rx_empty)
    );

    // Transmit path: host falling write edge pushes, chip side pops.
    pfb_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (wr_commit),
        .din  (bus_sync),
        .pop  (tx_out_ready),
        .dout (tx_out_data),
        .full (tx_full),
        .empty(tx_empty)
    );

    // Flag hold-off timers started at the end of each host cycle.
    pfb_holdoff #(.HOLD(HOLD_CYCLES)) u_rx_hold (
        .clk(clk), .rst_n(rst_n), .start(rd_done), .busy(rx_hold)
    );
    pfb_holdoff #(.HOLD(HOLD_CYCLES)) u_tx_hold (
        .clk(clk), .rst_n(rst_n), .start(wr_commit), .busy(tx_hold)
    );

    // Capture the popped byte. A read on an empty FIFO keeps the old one.
    always_ff @(posedge clk) begin
        if (!rst_n)                       out_byte <= '0;
        else if (rd_pop_evt && !rx_empty) out_byte <= rx_head;
    end

    // Drive enable follows the read strobe, starting once the byte is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= !rd_now && !rd_pop_evt;
    end

    assign host_data_out = out_byte;
    assign host_data_oe  = oe_q;
    assign host_rxf_n    = rx_empty || !rd_now || rx_hold;
    assign host_txe_n    = tx_full || wr_now || tx_hold;
    assign rx_in_ready   = !rx_full;
    assign tx_out_valid  = !tx_empty;
endmodule

// File: rtl/pfb_chk.sv
// Property checker for par_fifo_bridge, attached by bind. Hold-off windows
// are tracked with local counters so no parameter sets a $past depth.
module pfb_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned HOLD_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd_n,
    input logic              host_data_oe,
    input logic              host_rxf_n,
    input logic              host_txe_n,
    input logic              rd_done,
    input logic              wr_commit,
    input logic              rx_empty,
    input logic              tx_full,
    input logic              tx_out_valid,
    input logic              tx_out_ready,
    input logic [DATA_W-1:0] tx_out_data
);
    int unsigned rx_win, tx_win, since_rst;

    // Remaining clocks of each hold-off window, and cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_win    <= 0;
            tx_win    <= 0;
            since_rst <= 0;
        end else begin
            if (rd_done)          rx_win <= HOLD_CYCLES;
            else if (rx_win != 0) rx_win <= rx_win - 1;
            if (wr_commit)        tx_win <= HOLD_CYCLES;
            else if (tx_win != 0) tx_win <= tx_win - 1;
            if (since_rst < 4)    since_rst <= since_rst + 1;
        end
    end

    p_rxf_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> host_rxf_n);

    p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4 && $past(host_rd_n, 1) && $past(host_rd_n, 2) && $past(host_rd_n, 3))
        |-> !host_data_oe);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> host_txe_n);

    p_rxf_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done || rx_win != 0) |-> host_rxf_n);

    p_txe_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit || tx_win != 0) |-> host_txe_n);

    p_tx_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));
endmodule

bind par_fifo_bridge pfb_chk #(.DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd_n   (host_rd_n),
    .host_data_oe(host_data_oe),
    .host_rxf_n  (host_rxf_n),
    .host_txe_n  (host_txe_n),
    .rd_done     (rd_done),
    .wr_commit   (wr_commit),
    .rx_empty    (rx_empty),
    .tx_full     (tx_full),
    .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready),
    .tx_out_data (tx_out_data)
);

// File: tb/tb_par_fifo_bridge.sv
// Bench for par_fifo_bridge: a flag-respecting host model, a chip-side
// source and a randomly stalling sink, all checked against queues.
module tb_par_fifo_bridge;
    localparam int unsigned DW    = 8;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned HOLD  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_rd_n = 1'b1;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_data_in = '0;
    logic [DW-1:0] host_data_out;
    logic          host_data_oe, host_rxf_n, host_txe_n;
    logic [DW-1:0] rx_in_data = '0;
    logic          rx_in_valid = 1'b0;
    logic          rx_in_ready;
    logic [DW-1:0] tx_out_data;
    logic          tx_out_valid;
    logic          tx_out_ready = 1'b0;

    int unsigned   n_chk = 0, n_bad = 0;
    logic [DW-1:0] src_q[$], exp_rx[$], exp_tx[$];
    logic [DW-1:0] last_read = '0;
    bit            sink_en = 1'b0;

    always #5 clk = ~clk;

    par_fifo_bridge #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_rd_n(host_rd_n), .host_wr(host_wr), .host_data_in(host_data_in),
        .host_data_out(host_data_out), .host_data_oe(host_data_oe),
        .host_rxf_n(host_rxf_n), .host_txe_n(host_txe_n),
        .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Chip-side source: offer the queue head, record it once accepted.
    always @(negedge clk) begin
        if (src_q.size() > 0) begin
            rx_in_valid = 1'b1;
            rx_in_data  = src_q[0];
            if (rx_in_ready) exp_rx.push_back(src_q.pop_front());
        end else begin
            rx_in_valid = 1'b0;
        end
    end

    // Chip-side sink: random ready, each taken byte compared in order (R5).
    always @(negedge clk) begin
        logic r;
        r = sink_en ? 1'($urandom % 2) : 1'b0;
        tx_out_ready = r;
        if (r && tx_out_valid) begin
            if (exp_tx.size() == 0) chk(1'b0, "R5 unexpected tx byte", int'(tx_out_data), -1);
            else begin
                logic [DW-1:0] e;
                e = exp_tx.pop_front();
                chk(tx_out_data == e, "R5 tx order", int'(tx_out_data), int'(e));
            end
        end
    end

    // Host read cycle; forced reads ignore the flag.
    task automatic host_read(input bit forced);
        logic [DW-1:0] e;
        if (!forced) while (host_rxf_n) @(negedge clk);
        host_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(host_data_oe == 1'b1, "R4 oe during read", int'(host_data_oe), 1);
        chk(host_rxf_n == 1'b1, "R11 rxf high in read", int'(host_rxf_n), 1);
        if (forced) begin
            chk(host_data_out == last_read, "R7 empty read keeps byte", int'(host_data_out), int'(last_read));
        end else if (exp_rx.size() == 0) begin
            chk(1'b0, "R3 read without expected byte", int'(host_data_out), -1);
        end else begin
            e = exp_rx.pop_front();
            chk(host_data_out == e, "R3 rx order", int'(host_data_out), int'(e));
            last_read = host_data_out;
        end
        host_rd_n = 1'b1;
        for (int i = 0; i < int'(HOLD) + 2; i++) begin
            @(negedge clk);
            chk(host_rxf_n == 1'b1, "R8 rxf hold-off", int'(host_rxf_n), 1);
        end
        chk(host_data_oe == 1'b0, "R4 oe released", int'(host_data_oe), 0);
    endtask

    // Host write cycle; forced writes ignore the flag and expect no commit.
    task automatic host_write(input logic [DW-1:0] v, input bit forced);
        if (!forced) while (host_txe_n) @(negedge clk);
        host_data_in = v;
        host_wr = 1'b1;
        repeat (4) @(negedge clk);
        chk(host_txe_n == 1'b1, "R11 txe high in write", int'(host_txe_n), 1);
        if (!forced) exp_tx.push_back(v);
        host_wr = 1'b0;
        for (int i = 0; i < int'(HOLD) + 2; i++) begin
            @(negedge clk);
            chk(host_txe_n == 1'b1, "R9 txe hold-off", int'(host_txe_n), 1);
        end
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset
        chk(host_rxf_n == 1'b1, "R1 rxf", int'(host_rxf_n), 1);
        chk(host_txe_n == 1'b0, "R1 txe", int'(host_txe_n), 0);
        chk(host_data_oe == 1'b0, "R1 oe", int'(host_data_oe), 0);
        chk(rx_in_ready == 1'b1, "R1 rx ready", int'(rx_in_ready), 1);
        chk(tx_out_valid == 1'b0, "R1 tx valid", int'(tx_out_valid), 0);
        chk(host_data_out == '0, "R1 bus byte", int'(host_data_out), 0);

        // R7: read on an empty FIFO
        host_read(1'b1);

        // R2, R3: a few bytes through the receive side
        for (int i = 0; i < 5; i++) src_q.push_back(DW'(8'h10 + i));
        repeat (4) @(negedge clk);
        chk(host_rxf_n == 1'b0, "R2 rxf low with data", int'(host_rxf_n), 0);
        for (int i = 0; i < 5; i++) host_read(1'b0);
        repeat (2) @(negedge clk);
        chk(host_rxf_n == 1'b1, "R2 rxf high when empty", int'(host_rxf_n), 1);

        // R6: fill the transmit FIFO with the sink stalled, then overrun once
        for (int i = 0; i < int'(DEPTH); i++) host_write(DW'(8'hA0 + i), 1'b0);
        chk(host_txe_n == 1'b1, "R6 txe high when full", int'(host_txe_n), 1);
        chk(tx_out_valid == 1'b1, "R10 tx valid", int'(tx_out_valid), 1);
        host_write(8'hEE, 1'b1);
        sink_en = 1'b1;
        while (exp_tx.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(tx_out_valid == 1'b0, "R6 dropped write absent", int'(tx_out_valid), 0);
        chk(host_txe_n == 1'b0, "R6 txe low after drain", int'(host_txe_n), 0);

        // R10: fill the receive FIFO, one extra byte must wait
        for (int i = 0; i < int'(DEPTH) + 1; i++) src_q.push_back(DW'(8'h40 + i));
        repeat (40) @(negedge clk);
        chk(rx_in_ready == 1'b0, "R10 rx ready low when full", int'(rx_in_ready), 0);
        chk(src_q.size() == 1, "R10 extra byte held", src_q.size(), 1);
        while (exp_rx.size() > 0 || src_q.size() > 0) host_read(1'b0);

        // Random interleaving of both directions
        for (int i = 0; i < 200; i++) begin
            int unsigned op;
            op = $urandom % 4;
            if (op == 0 && src_q.size() < 6) begin
                src_q.push_back(DW'($urandom));
                @(negedge clk);
            end else if (op == 1 && !host_rxf_n) host_read(1'b0);
            else if (op == 2 && !host_txe_n) host_write(DW'($urandom), 1'b0);
            else @(negedge clk);
        end
        while (exp_rx.size() > 0 || src_q.size() > 0) host_read(1'b0);
        while (exp_tx.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(tx_out_valid == 1'b0, "R5 all writes delivered", int'(tx_out_valid), 0);
        chk(host_rxf_n == 1'b1, "R2 rx drained", int'(host_rxf_n), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule